// File: doc/BRIEF.md
# Wireless Security Key Table

This block holds the cipher keys for a wireless MAC's encryption engine. Each of its slots describes one key: a valid flag, a group/pairwise flag, a cipher type code, a two-bit key index, the 48-bit address of the peer station and a 128-bit key. Software fills a slot one 32-bit word at a time. It first writes a data register, then writes a command register that names the target word. The command register reads back a busy flag, which software polls before it issues the next word.

A combinational lookup port serves the encrypt and decrypt paths. Given a peer address, a key index and a direction, it returns a hit flag, the slot number, the cipher type and the key. Pairwise keys are found by address search. Broadcast frames use group keys. When direct-key search is switched on, the lowest four slots become group keys that are picked straight from the frame's key index, and the address search for pairwise keys starts above them.

Top module: `key_cam`

## Requirements
- R1: After reset the busy flag (command read-back bit 31) is 0, the read-back word is all zero, and no lookup hits, whatever the mode.
- R2: A command write with bit 16 set starts a store to the word at address bits 7:0, where slot = bits 7:3 and word = bits 2:0. It takes the data register's value from before that edge. Bit 31 then reads 1 for exactly two cycles and bits 7:0 read back the address. A command with bit 16 clear, or any command while busy, changes nothing.
- R3: Word 0 sets, in one store, the key index (bits 1:0), the cipher type (bits 4:2), the group flag (bit 6), the valid flag (bit 15) and peer address bytes 0 and 1 (bits 23:16 and 31:24). A hit returns that cipher type.
- R4: Word 1 carries peer bytes 2..5, with byte 2 in bits 7:0. Words 2..5 carry key bytes 0..15, low byte first. The lookup peer and the returned key use the same byte order: byte n sits in bits 8n+7:8n.
- R5: A store to any word other than 0 clears that slot's valid flag. The slot therefore matches nothing until word 0 is stored with bit 15 set.
- R6: Storing zero to word 0 clears the slot, and it stops matching.
- R7: On a unicast lookup without the direct-key path, the block hits on the lowest-numbered valid non-group slot whose peer address is equal. On a miss the slot, type and key outputs are zero.
- R8: Direct-key search is on when it is enabled and the direct-key enable for the frame's kind is set (unicast or broadcast, tx or rx). In that case the slot equals the key index, and the lookup hits only if that slot is valid and a group slot.
- R9: While direct-key search is enabled, the pairwise address search skips slots 0..3.
- R10: A broadcast lookup (peer all ones) that does not take the direct-key path hits on the lowest valid group slot whose key index is equal.
- R11: When the encryption enable for the lookup's direction is off, the lookup never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_we | input | 1 | Write strobe for the data register |
| data_wdata | input | 32 | Data register value |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command: bit 31 poll, bit 16 write enable, bits 7:0 word address |
| cmd_rdata | output | 32 | Read-back: bit 31 busy, bits 7:0 last accepted address |
| cfg_direct_search | input | 1 | Reserve slots 0..3 as directly indexed group keys |
| cfg_tx_en | input | 1 | Encryption enable for transmit lookups |
| cfg_rx_en | input | 1 | Decryption enable for receive lookups |
| cfg_tx_uc_direct | input | 1 | Transmit unicast uses direct keys |
| cfg_rx_uc_direct | input | 1 | Receive unicast uses direct keys |
| cfg_tx_bc_direct | input | 1 | Transmit broadcast uses direct keys |
| cfg_rx_bc_direct | input | 1 | Receive broadcast uses direct keys |
| lk_peer | input | 48 | Peer address to look up, byte 0 in bits 7:0 |
| lk_kidx | input | 2 | Key index carried by the frame |
| lk_is_tx | input | 1 | 1 for transmit, 0 for receive |
| lk_hit | output | 1 | A slot matched |
| lk_slot | output | 5 | Matching slot number |
| lk_ctype | output | 3 | Cipher type of the matching slot |
| lk_key | output | 128 | Key of the matching slot, byte 0 in bits 7:0 |

## Verification
Random lookups are drawn from a pool of four peer addresses plus broadcast, against a table loaded at random. Duplicate addresses and mixed group and pairwise slots make the lowest-index rule, the group/pairwise split and the reserved-slot rule each decide some outcomes. Random settings of all seven configuration inputs separate the direct-key path from address search, and direction from direction. Directed sequences target the store protocol: busy timing, commands that must be ignored, a slot rewritten word by word so that it stays dark until word 0 arrives, and a one-word clear.

// File: rtl/key_cam_pkg.sv
// Shared types for the key table.
// Assumes: peer addresses are 48 bits, keys are 128 bits, and the key index is 2 bits wide.
package key_cam_pkg;
    localparam int WORD_W = 32;
    localparam int PEER_W = 48;
    localparam int KEY_W  = 128;

    // Decoded contents of one slot.
    typedef struct packed {
        logic              valid;
        logic              group;
        logic [2:0]        ctype;
        logic [1:0]        kidx;
        logic [PEER_W-1:0] peer;
        logic [KEY_W-1:0]  key;
    } slot_t;

    // Lookup result bundle.
    typedef struct packed {
        logic              hit;
        logic [2:0]        ctype;
        logic [KEY_W-1:0]  key;
    } lk_res_t;
endpackage

// File: rtl/key_cam_regif.sv
// Host register pair: the data register and the command register.
// An accepted command latches the data and the word address, stores the word
// in the next cycle, then stays busy for one more cycle.
// Assumes: WE_BIT and POLL_BIT lie above the address field.
module key_cam_regif #(
    parameter int ADDR_W   = 8,
    parameter int WE_BIT   = 16,
    parameter int POLL_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [31:0]       data_in,
    input  logic              cmd_we,
    input  logic [31:0]       cmd_in,
    output logic [31:0]       cmd_out,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              busy
);
    typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_DRAIN} st_t;

    st_t               state;
    logic [31:0]       data_q;
    logic [ADDR_W-1:0] addr_q;
    logic [31:0]       pend_q;
    logic              unused_cmd;

    assign unused_cmd = ^cmd_in;

    // Hold the value last written by software to the data register.
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (data_we) data_q <= data_in;
    end

    // Command sequencer: idle, then store, then drain, then idle again.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            pend_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_we && cmd_in[WE_BIT]) begin
                    state  <= ST_STORE;
                    addr_q <= cmd_in[ADDR_W-1:0];
                    pend_q <= data_q;
                end
                ST_STORE: state <= ST_DRAIN;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign wr_en   = (state == ST_STORE);
    assign wr_addr = addr_q;
    assign wr_data = pend_q;

    // Build the read-back word from the busy flag and the last address.
    always_comb begin
        cmd_out               = '0;
        cmd_out[POLL_BIT]     = busy;
        cmd_out[ADDR_W-1:0]   = addr_q;
    end
endmodule

// File: rtl/key_cam_store.sv
// Slot array. Each word store updates the decoded fields of one slot.
// Word 0 writes the control fields and peer bytes 0..1 together. Any other
// word writes its field and clears the valid flag, so a slot being rewritten
// stays dark until word 0 arrives.
// Assumes: at most one store per cycle.
module key_cam_store
    import key_cam_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int SLOT_W  = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SLOT_W-1:0]         wr_slot,
    input  logic [2:0]                wr_off,
    input  logic [WORD_W-1:0]         wr_data,
    output slot_t [N_SLOTS-1:0]       tab
);
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_slot == SLOT_W'(g));

        // Apply a word store that targets this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tab[g] <= '0;
            end else if (sel) begin
                unique case (wr_off)
                    3'd0: begin
                        tab[g].kidx       <= wr_data[1:0];
                        tab[g].ctype      <= wr_data[4:2];
                        tab[g].group      <= wr_data[6];
                        tab[g].valid      <= wr_data[15];
                        tab[g].peer[7:0]  <= wr_data[23:16];
                        tab[g].peer[15:8] <= wr_data[31:24];
                    end
                    3'd1: begin
                        tab[g].peer[47:16] <= wr_data;
                        tab[g].valid       <= 1'b0;
                    end
                    3'd2: begin
                        tab[g].key[31:0] <= wr_data;
                        tab[g].valid     <= 1'b0;
                    end
                    3'd3: begin
                        tab[g].key[63:32] <= wr_data;
                        tab[g].valid      <= 1'b0;
                    end
                    3'd4: begin
                        tab[g].key[95:64] <= wr_data;
                        tab[g].valid      <= 1'b0;
                    end
                    3'd5: begin
                        tab[g].key[127:96] <= wr_data;
                        tab[g].valid       <= 1'b0;
                    end
                    default: tab[g].valid <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/key_cam_match.sv
// Combinational lookup. It picks one of three ways to find a slot: the
// direct-key path, the group search for broadcast, or the pairwise address
// search. The lowest index wins. Outputs are zero on a miss.
// Assumes: DIRECT_SLOTS equals the number of key index values (4).
module key_cam_match
    import key_cam_pkg::*;
#(
    parameter int N_SLOTS      = 32,
    parameter int SLOT_W       = 5,
    parameter int DIRECT_SLOTS = 4
) (
    input  slot_t [N_SLOTS-1:0] tab,
    input  logic [PEER_W-1:0]   lk_peer,
    input  logic [1:0]          lk_kidx,
    input  logic                lk_is_tx,
    input  logic                cfg_direct_search,
    input  logic                cfg_tx_en,
    input  logic                cfg_rx_en,
    input  logic                cfg_tx_uc_direct,
    input  logic                cfg_rx_uc_direct,
    input  logic                cfg_tx_bc_direct,
    input  logic                cfg_rx_bc_direct,
    output logic                hit,
    output logic [SLOT_W-1:0]   slot,
    output logic [2:0]          ctype,
    output logic [KEY_W-1:0]    key
);
    logic [N_SLOTS-1:0] pair_v;
    logic [N_SLOTS-1:0] grp_v;
    logic               bcast, enc_on, use_direct;
    logic               found;
    logic [SLOT_W-1:0]  sel;
    logic [SLOT_W-1:0]  pair_idx, grp_idx;
    logic               pair_any, grp_any;

    // Per-slot candidate flags for the two search paths.
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
        logic allowed;
        assign allowed  = (g >= DIRECT_SLOTS) ? 1'b1 : !cfg_direct_search;
        assign pair_v[g] = tab[g].valid && !tab[g].group && allowed &&
                           (tab[g].peer == lk_peer);
        assign grp_v[g]  = tab[g].valid && tab[g].group && (tab[g].kidx == lk_kidx);
    end

    // Index of the lowest set bit of a vector.
    function automatic logic [SLOT_W-1:0] lowest(input logic [N_SLOTS-1:0] v);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (v[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

    assign pair_any = |pair_v;
    assign grp_any  = |grp_v;
    assign pair_idx = lowest(pair_v);
    assign grp_idx  = lowest(grp_v);

    assign bcast      = &lk_peer;
    assign enc_on     = lk_is_tx ? cfg_tx_en : cfg_rx_en;
    assign use_direct = cfg_direct_search &&
                        (bcast ? (lk_is_tx ? cfg_tx_bc_direct : cfg_rx_bc_direct)
                               : (lk_is_tx ? cfg_tx_uc_direct : cfg_rx_uc_direct));

    // Choose the search path and the winning slot.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        if (enc_on) begin
            if (use_direct) begin
                sel   = SLOT_W'(lk_kidx);
                found = tab[sel].valid && tab[sel].group;
            end else if (bcast) begin
                sel   = grp_idx;
                found = grp_any;
            end else begin
                sel   = pair_idx;
                found = pair_any;
            end
        end
    end

    // Present the winner, or zeros on a miss.
    always_comb begin
        hit   = found;
        slot  = found ? sel : '0;
        ctype = found ? tab[sel].ctype : 3'd0;
        key   = found ? tab[sel].key : '0;
    end
endmodule

// File: rtl/key_cam.sv
// Top of the security key table: register interface, slot array and lookup.
// Assumes: 8 words per slot, so the word address is {slot, word}.
module key_cam
    import key_cam_pkg::*;
#(
    parameter int N_SLOTS      = 32,
    parameter int DIRECT_SLOTS = 4,
    parameter int CMD_WE_BIT   = 16,
    parameter int CMD_POLL_BIT = 31
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_we,
    input  logic [31:0]  data_wdata,
    input  logic         cmd_we,
    input  logic [31:0]  cmd_wdata,
    output logic [31:0]  cmd_rdata,
    input  logic         cfg_direct_search,
    input  logic         cfg_tx_en,
    input  logic         cfg_rx_en,
    input  logic         cfg_tx_uc_direct,
    input  logic         cfg_rx_uc_direct,
    input  logic         cfg_tx_bc_direct,
    input  logic         cfg_rx_bc_direct,
    input  logic [47:0]  lk_peer,
    input  logic [1:0]   lk_kidx,
    input  logic         lk_is_tx,
    output logic         lk_hit,
    output logic [4:0]   lk_slot,
    output logic [2:0]   lk_ctype,
    output logic [127:0] lk_key
);
    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam int OFF_W  = 3;
    localparam int ADDR_W = SLOT_W + OFF_W;

    logic                 wr_en, busy;
    logic [ADDR_W-1:0]    wr_addr;
    logic [WORD_W-1:0]    wr_data;
    logic [SLOT_W-1:0]    wr_slot;
    logic [OFF_W-1:0]     wr_off;
    slot_t [N_SLOTS-1:0]  tab;
    logic [N_SLOTS-1:0]   valid_vec;

    assign wr_slot = wr_addr[ADDR_W-1:OFF_W];
    assign wr_off  = wr_addr[OFF_W-1:0];

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_vv
        assign valid_vec[g] = tab[g].valid;
    end

    key_cam_regif #(
        .ADDR_W  (ADDR_W),
        .WE_BIT  (CMD_WE_BIT),
        .POLL_BIT(CMD_POLL_BIT)
    ) u_regif (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_we(data_we),
        .data_in(data_wdata),
        .cmd_we (cmd_we),
        .cmd_in (cmd_wdata),
        .cmd_out(cmd_rdata),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .busy   (busy)
    );

    key_cam_store #(
        .N_SLOTS(N_SLOTS),
        .SLOT_W (SLOT_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_slot(wr_slot),
        .wr_off (wr_off),
        .wr_data(wr_data),
        .tab    (tab)
    );

    key_cam_match #(
        .N_SLOTS     (N_SLOTS),
        .SLOT_W      (SLOT_W),
        .DIRECT_SLOTS(DIRECT_SLOTS)
    ) u_match (
        .tab              (tab),
        .lk_peer          (lk_peer),
        .lk_kidx          (lk_kidx),
        .lk_is_tx         (lk_is_tx),
        .cfg_direct_search(cfg_direct_search),
        .cfg_tx_en        (cfg_tx_en),
        .cfg_rx_en        (cfg_rx_en),
        .cfg_tx_uc_direct (cfg_tx_uc_direct),
        .cfg_rx_uc_direct (cfg_rx_uc_direct),
        .cfg_tx_bc_direct (cfg_tx_bc_direct),
        .cfg_rx_bc_direct (cfg_rx_bc_direct),
        .hit              (lk_hit),
        .slot             (lk_slot),
        .ctype            (lk_ctype),
        .key              (lk_key)
    );
endmodule

// File: rtl/key_cam_chk.sv
// Protocol and lookup checks for key_cam, attached through bind.
// Assumes: the internal store strobe, its address and the valid flags are
// visible at the top.
module key_cam_chk #(
    parameter int N_SLOTS = 32,
    parameter int SLOT_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               wr_en,
    input logic [SLOT_W-1:0]  wr_slot,
    input logic [2:0]         wr_off,
    input logic [31:0]        wr_data,
    input logic [N_SLOTS-1:0] valid_vec,
    input logic [47:0]        lk_peer,
    input logic [1:0]         lk_kidx,
    input logic               lk_is_tx,
    input logic               cfg_direct_search,
    input logic               cfg_tx_en,
    input logic               cfg_rx_en,
    input logic               lk_hit,
    input logic [4:0]         lk_slot,
    input logic [2:0]         lk_ctype,
    input logic [127:0]       lk_key
);
    // Busy lasts at least two cycles once raised (R2).
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // Busy never lasts more than two cycles (R2).
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |=> !busy);

    // A store to a word other than 0 leaves its slot invalid (R5).
    assert_arm_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_off != 3'd0) |=> !valid_vec[$past(wr_slot)]);

    // Storing word 0 with the valid bit clear removes the slot (R6).
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_off == 3'd0) && !wr_data[15] |=> !valid_vec[$past(wr_slot)]);

    // A hit always names a valid slot (R7).
    assert_hit_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> valid_vec[lk_slot]);

    // Miss outputs are zero (R7).
    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_slot == 5'd0) && (lk_ctype == 3'd0) && (lk_key == '0));

    // With direct search on, a unicast hit below slot 4 is the direct slot (R9).
    assert_low_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && cfg_direct_search && !(&lk_peer) && (lk_slot < 5'd4)
        |-> lk_slot == {3'b000, lk_kidx});

    // A disabled direction never hits (R11).
    assert_dir_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_is_tx ? !cfg_tx_en : !cfg_rx_en) |-> !lk_hit);
endmodule

bind key_cam key_cam_chk #(
    .N_SLOTS(N_SLOTS),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .busy             (busy),
    .wr_en            (wr_en),
    .wr_slot          (wr_slot),
    .wr_off           (wr_off),
    .wr_data          (wr_data),
    .valid_vec        (valid_vec),
    .lk_peer          (lk_peer),
    .lk_kidx          (lk_kidx),
    .lk_is_tx         (lk_is_tx),
    .cfg_direct_search(cfg_direct_search),
    .cfg_tx_en        (cfg_tx_en),
    .cfg_rx_en        (cfg_rx_en),
    .lk_hit           (lk_hit),
    .lk_slot          (lk_slot),
    .lk_ctype         (lk_ctype),
    .lk_key           (lk_key)
);

// File: tb/key_cam_bench.sv
module key_cam_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         data_we = 1'b0;
    logic [31:0]  data_wdata = '0;
    logic         cmd_we = 1'b0;
    logic [31:0]  cmd_wdata = '0;
    logic [31:0]  cmd_rdata;
    logic         c_dir = 0, c_tx = 1, c_rx = 1, c_txuc = 0, c_rxuc = 0, c_txbc = 0, c_rxbc = 0;
    logic [47:0]  lk_peer = '0;
    logic [1:0]   lk_kidx = '0;
    logic         lk_is_tx = 1'b0;
    logic         lk_hit;
    logic [4:0]   lk_slot;
    logic [2:0]   lk_ctype;
    logic [127:0] lk_key;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench-side model of the table contents.
    bit          m_valid [32];
    bit          m_group [32];
    logic [2:0]  m_ctype [32];
    logic [1:0]  m_kidx  [32];
    logic [47:0] m_peer  [32];
    logic [127:0] m_key  [32];

    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    key_cam u_key_cam (
        .clk(clk), .rst_n(rst_n),
        .data_we(data_we), .data_wdata(data_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .cfg_direct_search(c_dir), .cfg_tx_en(c_tx), .cfg_rx_en(c_rx),
        .cfg_tx_uc_direct(c_txuc), .cfg_rx_uc_direct(c_rxuc),
        .cfg_tx_bc_direct(c_txbc), .cfg_rx_bc_direct(c_rxbc),
        .lk_peer(lk_peer), .lk_kidx(lk_kidx), .lk_is_tx(lk_is_tx),
        .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_ctype(lk_ctype), .lk_key(lk_key)
    );

    task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Apply one accepted word store to the model.
    task automatic model_word(input int s, input int off, input logic [31:0] d);
        case (off)
            0: begin
                m_kidx[s] = d[1:0]; m_ctype[s] = d[4:2]; m_group[s] = d[6];
                m_valid[s] = d[15]; m_peer[s][15:0] = {d[31:24], d[23:16]};
            end
            1: begin m_peer[s][47:16] = d; m_valid[s] = 0; end
            2, 3, 4, 5: begin m_key[s][32*(off-2) +: 32] = d; m_valid[s] = 0; end
            default: m_valid[s] = 0;
        endcase
    endtask

    // Software sequence: data register, command register, poll until idle.
    task automatic write_word(input int s, input int off, input logic [31:0] d);
        @(negedge clk);
        data_we = 1; data_wdata = d;
        @(negedge clk);
        data_we = 0;
        cmd_we = 1; cmd_wdata = 32'h8001_0000 | 32'((s << 3) | off);
        @(negedge clk);
        cmd_we = 0;
        while (cmd_rdata[31]) @(negedge clk);
        model_word(s, off, d);
    endtask

    function automatic logic [31:0] word0(input bit v, input bit g, input logic [2:0] ct,
                                          input logic [1:0] ki, input logic [47:0] p);
        return {p[15:8], p[7:0], v, 8'd0, g, 1'b0, ct, ki};
    endfunction

    task automatic load(input int s, input bit v, input bit g, input logic [2:0] ct,
                        input logic [1:0] ki, input logic [47:0] p, input logic [127:0] k);
        for (int off = 7; off >= 0; off--) begin
            case (off)
                0: write_word(s, 0, word0(v, g, ct, ki, p));
                1: write_word(s, 1, p[47:16]);
                6, 7: write_word(s, off, 32'd0);
                default: write_word(s, off, k[32*(off-2) +: 32]);
            endcase
        end
    endtask

    // Expected lookup result from the requirements: {hit, slot, ctype, key}.
    function automatic logic [136:0] expect_lk(input logic [47:0] p, input logic [1:0] ki, input bit tx);
        bit bc, dir;
        if (!(tx ? c_tx : c_rx)) return '0;                      // R11
        bc  = (p == BCAST);
        dir = c_dir && (bc ? (tx ? c_txbc : c_rxbc) : (tx ? c_txuc : c_rxuc));
        if (dir) begin                                           // R8
            if (m_valid[ki] && m_group[ki]) return {1'b1, 3'd0, ki, m_ctype[ki], m_key[ki]};
            return '0;
        end
        for (int s = 0; s < 32; s++) begin
            if (bc && m_valid[s] && m_group[s] && m_kidx[s] == ki)          // R10
                return {1'b1, 5'(s), m_ctype[s], m_key[s]};
            if (!bc && m_valid[s] && !m_group[s] && m_peer[s] == p && (!c_dir || s >= 4)) // R7, R9
                return {1'b1, 5'(s), m_ctype[s], m_key[s]};
        end
        return '0;
    endfunction

    task automatic lookup_check(input logic [47:0] p, input logic [1:0] ki, input bit tx, input string req);
        logic [136:0] e, a;
        @(negedge clk);
        lk_peer = p; lk_kidx = ki; lk_is_tx = tx;
        #2;
        a = {lk_hit, lk_slot, lk_ctype, lk_key};
        e = expect_lk(p, ki, tx);
        check(a == e, req, 160'(a), 160'(e));
    endtask

    task automatic set_cfg(input bit d, input bit tx, input bit rx, input bit tuc,
                           input bit ruc, input bit tbc, input bit rbc);
        @(negedge clk);
        c_dir = d; c_tx = tx; c_rx = rx; c_txuc = tuc; c_rxuc = ruc; c_txbc = tbc; c_rxbc = rbc;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        logic [47:0]  pool [4];
        logic [47:0]  pa, pb;
        logic [127:0] ka;
        logic [31:0]  seed;
        seed = $urandom(32'd8675309);
        for (int s = 0; s < 32; s++) begin
            m_valid[s] = 0; m_group[s] = 0; m_ctype[s] = 0; m_kidx[s] = 0; m_peer[s] = 0; m_key[s] = 0;
        end
        pa = 48'h665544332211;
        pb = 48'h0A0B0C0D0E0F;
        ka = 128'h0F0E0D0C0B0A09080706050403020100;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check(cmd_rdata == 32'd0, "R1 readback", 160'(cmd_rdata), 160'd0);
        set_cfg(1, 1, 1, 1, 1, 1, 1);
        lookup_check(BCAST, 2'd0, 1'b0, "R1 direct miss");
        set_cfg(0, 1, 1, 0, 0, 0, 0);
        lookup_check(48'd0, 2'd0, 1'b1, "R1 pairwise miss");
        lookup_check(BCAST, 2'd3, 1'b1, "R1 group miss");

        // R3, R4, R7: a pairwise slot is loaded and found
        load(2, 1, 0, 3'd4, 2'd1, pa, ka);
        lookup_check(pa, 2'd0, 1'b0, "R3 R4 R7 pairwise hit");
        check(lk_key[7:0] == 8'h00 && lk_key[127:120] == 8'h0F, "R4 key byte order",
              160'(lk_key), 160'(ka));
        check(cmd_rdata[7:0] == 8'h10, "R2 address readback", 160'(cmd_rdata[7:0]), 160'h10);

        // R2: busy timing
        @(negedge clk);
        data_we = 1; data_wdata = 32'h1234_5678;
        @(negedge clk);
        data_we = 0; cmd_we = 1; cmd_wdata = 32'h8001_0000 | 32'((6 << 3) | 4);
        @(negedge clk);
        cmd_we = 0;
        check(cmd_rdata[31] == 1'b1, "R2 busy cycle 1", 160'(cmd_rdata), 160'h8000_0034);
        // R2: a command while busy is ignored
        cmd_we = 1; cmd_wdata = 32'h8001_0000 | 32'((6 << 3) | 0);
        @(negedge clk);
        cmd_we = 0;
        check(cmd_rdata[31] == 1'b1 && cmd_rdata[7:0] == 8'h34, "R2 busy cycle 2",
              160'(cmd_rdata), 160'h8000_0034);
        @(negedge clk);
        check(cmd_rdata[31] == 1'b0, "R2 busy cleared", 160'(cmd_rdata), 160'h34);
        model_word(6, 4, 32'h1234_5678);
        check(cmd_rdata[7:0] == 8'h34, "R2 busy command ignored", 160'(cmd_rdata[7:0]), 160'h34);

        // R2: a command without the write-enable bit is ignored
        @(negedge clk);
        data_we = 1; data_wdata = 32'd0;
        @(negedge clk);
        data_we = 0; cmd_we = 1; cmd_wdata = 32'h8000_0000 | 32'(2 << 3);
        @(negedge clk);
        cmd_we = 0;
        check(cmd_rdata == 32'h0000_0034, "R2 no-enable ignored", 160'(cmd_rdata), 160'h34);
        lookup_check(pa, 2'd0, 1'b0, "R2 slot kept after ignored command");

        // R5: rewriting a key word drops valid until word 0
        write_word(2, 3, 32'hCAFE_F00D);
        lookup_check(pa, 2'd0, 1'b0, "R5 dark after word 3");
        check(!lk_hit, "R5 dark", 160'(lk_hit), 160'd0);
        write_word(2, 0, word0(1, 0, 3'd2, 2'd0, pa));
        lookup_check(pa, 2'd0, 1'b0, "R5 back after word 0");
        check(lk_hit && lk_key[63:32] == 32'hCAFE_F00D, "R5 new key word",
              160'(lk_key), 160'h0000_0000_CAFE_F00D_0000_0000);

        // R6: one-word clear
        write_word(2, 0, 32'd0);
        lookup_check(pa, 2'd0, 1'b0, "R6 cleared");

        // R7: lowest index wins among duplicates
        load(9, 1, 0, 3'd1, 2'd0, pb, ~ka);
        load(7, 1, 0, 3'd3, 2'd0, pb, ka);
        lookup_check(pb, 2'd0, 1'b1, "R7 lowest duplicate");

        // R9: with direct search on, slot 3 is skipped by the address search
        load(3, 1, 0, 3'd5, 2'd0, pb, 128'h33);
        set_cfg(0, 1, 1, 0, 0, 0, 0);
        lookup_check(pb, 2'd0, 1'b1, "R9 off uses slot 3");
        set_cfg(1, 1, 1, 0, 0, 0, 0);
        lookup_check(pb, 2'd0, 1'b1, "R9 on skips slot 3");

        // R8: direct-key path by key index
        load(1, 1, 1, 3'd6, 2'd1, BCAST, 128'h11);
        set_cfg(1, 1, 1, 0, 0, 0, 1);
        lookup_check(BCAST, 2'd1, 1'b0, "R8 direct group hit");
        lookup_check(BCAST, 2'd3, 1'b0, "R8 direct pairwise slot miss");
        set_cfg(1, 1, 1, 1, 0, 0, 0);
        lookup_check(pb, 2'd1, 1'b1, "R8 direct unicast tx");

        // R10: broadcast group search by key index
        load(20, 1, 1, 3'd7, 2'd2, BCAST, 128'h2020);
        set_cfg(0, 1, 1, 0, 0, 0, 0);
        lookup_check(BCAST, 2'd2, 1'b0, "R10 group by index");
        lookup_check(BCAST, 2'd1, 1'b1, "R10 group slot 1");

        // R11: disabled direction
        set_cfg(0, 0, 1, 0, 0, 0, 0);
        lookup_check(pb, 2'd0, 1'b1, "R11 tx off");
        set_cfg(0, 1, 0, 0, 0, 0, 0);
        lookup_check(BCAST, 2'd2, 1'b0, "R11 rx off");

        // Random mix: R3 R4 R7 R8 R9 R10 R11
        pool[0] = pa; pool[1] = pb; pool[2] = 48'h00E0_4C12_3456; pool[3] = 48'h0200_0000_0001;
        for (int r = 0; r < 24; r++) begin
            int s;
            bit g;
            s = int'($urandom % 32);
            g = ($urandom % 3) == 0;
            load(s, ($urandom % 8) != 0, g, 3'($urandom), 2'($urandom),
                 g ? BCAST : pool[$urandom % 4],
                 {$urandom, $urandom, $urandom, $urandom});
            if (r % 4 == 3) begin
                for (int q = 0; q < 40; q++) begin
                    logic [5:0] cf;
                    cf = 6'($urandom);
                    set_cfg(cf[0], ($urandom % 5) != 0, ($urandom % 5) != 0,
                            cf[1], cf[2], cf[3], cf[4]);
                    lookup_check(($urandom % 4 == 0) ? BCAST : pool[$urandom % 4],
                                 2'($urandom), cf[5], "R7 R8 R9 R10 R11 random");
                end
            end
        end

        summary();
    end
endmodule